// File: doc/BRIEF.md
# Paged MDIO Register Bridge

This block sits behind an MDIO slave decoder and lets a management host reach a 32-bit internal register space through 16-bit MDIO transactions. Each decoded transaction arrives as one request beat carrying a direction, a PHY address, a register number and 16 bits of write data. The block keeps a page register. It folds the page, the low PHY address bits and the register number into a word address. It joins two 16-bit halves into one 32-bit access on a simple internal register bus.

The page is loaded by a write to PHY address 0x1F, register 0x10. Data accesses use PHY addresses 0x10 to 0x17. An even register number selects the low half of a word and the next odd number selects the high half. A host writes the high half first: it is staged, and the 32-bit write goes out when the low half arrives. A host reads the low half first: that read performs the 32-bit bus read and keeps the upper half, and the following high-half read is answered from that kept copy.

Requests use valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Read responses use valid/ready as well. Once `rsp_valid` is high, it and `rsp_data` hold until a cycle with `rsp_ready` high. While a read is in flight or its response is unconsumed, `req_ready` stays low and further requests wait.

Top module: `mdio_page_bridge`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid`, `reg_we` and `reg_re` are 0, and the page is 0.
- R2: A write to PHY 0x1F register 0x10 loads the page from data bits 8:0 and drives no bus strobe. A read of that address returns the page, zero-extended, one cycle after acceptance.
- R3: A data access to PHY address p in 0x10..0x17 with register number r targets the byte address {page, p[2:0], r[4:1], 2'b00}, which is 18 bits wide.
- R4: A write to an odd register number (the high half) stages its 16-bit data and drives no bus strobe.
- R5: A write to an even register number (the low half) pulses `reg_we` for one cycle, in the cycle after acceptance. `reg_wdata` is {staged high half, low data}. The staged half is kept for later low-half writes.
- R6: A read of an even register number pulses `reg_re` in the cycle after acceptance and samples `reg_rdata` in that cycle. `rsp_valid` rises one cycle later and carries `reg_rdata[15:0]`.
- R7: A read of an odd register number drives no strobe. It returns, one cycle after acceptance, the upper 16 bits kept from the latest low-half read, even if the bus word has changed since then.
- R8: Accesses to PHY addresses outside 0x10..0x17 and 0x1F, and to PHY 0x1F at any register other than 0x10, are ignored. Writes change neither the page, nor the staged half, nor the bus. Reads return 0xFFFF one cycle after acceptance.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold. `req_ready` is low from a read's acceptance until its response is consumed.
- R10: `reg_we` and `reg_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request beat valid |
| req_ready | output | 1 | Bridge can take a request |
| req_write | input | 1 | 1 = MDIO write, 0 = MDIO read |
| req_phy | input | 5 | Decoded PHY address |
| req_reg | input | 5 | Decoded register number |
| req_wdata | input | 16 | MDIO write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 16 | Read response data |
| reg_addr | output | 18 | Internal byte address, low two bits zero |
| reg_wdata | output | 32 | Internal write data |
| reg_we | output | 1 | Internal write strobe, one cycle |
| reg_re | output | 1 | Internal read strobe, one cycle |
| reg_rdata | input | 32 | Internal read data, valid in the `reg_re` cycle |

## Verification
The bench builds the bridge with its default parameters: a 9-bit page, a page select at PHY 0x1F register 0x10, and data PHY addresses based at 0x10. With a 9-bit page, an all-ones page value drives every address bit. Pages 0x000, 0x155 and 0x1FF then show that the page, PHY and register fields land in distinct bit positions. The bench's bus model returns a word derived from the address with an adjustable offset. Changing the offset between a low-half and a high-half read shows whether the high half comes from the kept copy.

// File: rtl/mdio_pb_pkg.sv
package mdio_pb_pkg;

  // Class of one decoded MDIO access
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_PAGE = 2'd1,
    ACC_DATA = 2'd2
  } acc_kind_e;

  // Indices of the two 16-bit holding registers
  localparam int unsigned HOLD_STAGE = 0;  // high half of a pending write
  localparam int unsigned HOLD_SNAP  = 1;  // high half of the last read
  localparam int unsigned HOLD_NUM   = 2;

endpackage

// File: rtl/mdio_pb_decode.sv
module mdio_pb_decode
  import mdio_pb_pkg::*;
#(
  parameter int unsigned PAGE_W        = 9,
  parameter logic [4:0]  PAGE_PHY      = 5'h1F,
  parameter logic [4:0]  PAGE_REG      = 5'h10,
  parameter logic [4:0]  DATA_PHY_BASE = 5'h10,
  localparam int unsigned WIDX_W       = PAGE_W + 7
) (
  input  logic [4:0]        phy,
  input  logic [4:0]        regn,
  input  logic [PAGE_W-1:0] page,
  output acc_kind_e         kind,
  output logic              hi_half,
  output logic [WIDX_W-1:0] word_idx
);

  // Data window spans eight PHY addresses aligned to the base
  logic data_hit;
  logic page_hit;

  always_comb begin
    data_hit = (phy[4:3] == DATA_PHY_BASE[4:3]);
    page_hit = (phy == PAGE_PHY) && (regn == PAGE_REG);
    if (page_hit) begin
      kind = ACC_PAGE;
    end else if (data_hit) begin
      kind = ACC_DATA;
    end else begin
      kind = ACC_NONE;
    end
    hi_half  = regn[0];
    word_idx = {page, phy[2:0], regn[4:1]};
  end

endmodule

// File: rtl/mdio_pb_halves.sv
module mdio_pb_halves
  import mdio_pb_pkg::*;
#(
  parameter int unsigned HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HOLD_NUM-1:0] load,
  input  logic [HALF_W-1:0] stage_in,
  input  logic [HALF_W-1:0] snap_in,
  output logic [HALF_W-1:0] stage_q,
  output logic [HALF_W-1:0] snap_q
);

  logic [HALF_W-1:0] din  [HOLD_NUM];
  logic [HALF_W-1:0] hold [HOLD_NUM];

  assign din[HOLD_STAGE] = stage_in;
  assign din[HOLD_SNAP]  = snap_in;

  for (genvar g = 0; g < HOLD_NUM; g++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hold[g] <= '0;
      end else if (load[g]) begin
        hold[g] <= din[g];
      end
    end
  end

  assign stage_q = hold[HOLD_STAGE];
  assign snap_q  = hold[HOLD_SNAP];

endmodule

// File: rtl/mdio_pb_resp.sv
module mdio_pb_resp #(
  parameter int unsigned HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              read_take,
  input  logic              load,
  input  logic [HALF_W-1:0] load_data,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [HALF_W-1:0] rsp_data,
  output logic              busy
);

  logic done;
  assign done = rsp_valid && rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      busy      <= 1'b0;
    end else begin
      if (load) begin
        rsp_valid <= 1'b1;
        rsp_data  <= load_data;
      end else if (done) begin
        rsp_valid <= 1'b0;
      end
      if (read_take) begin
        busy <= 1'b1;
      end else if (done) begin
        busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
  import mdio_pb_pkg::*;
#(
  parameter int unsigned PAGE_W        = 9,
  parameter logic [4:0]  PAGE_PHY      = 5'h1F,
  parameter logic [4:0]  PAGE_REG      = 5'h10,
  parameter logic [4:0]  DATA_PHY_BASE = 5'h10,
  parameter int unsigned HALF_W        = 16,
  localparam int unsigned WORD_W       = 2 * HALF_W,
  localparam int unsigned WIDX_W       = PAGE_W + 7,
  localparam int unsigned ADDR_W       = WIDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [4:0]        req_phy,
  input  logic [4:0]        req_reg,
  input  logic [HALF_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [HALF_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [WORD_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [WORD_W-1:0] reg_rdata
);

  localparam logic [HALF_W-1:0] IDLE_READ = '1;

  logic [PAGE_W-1:0] page_q;
  acc_kind_e         kind;
  logic              hi_half;
  logic [WIDX_W-1:0] word_idx;
  logic              take;
  logic              busy;
  logic [HALF_W-1:0] stage_q;
  logic [HALF_W-1:0] snap_q;
  logic [HOLD_NUM-1:0] hold_load;
  logic              rsp_load;
  logic [HALF_W-1:0] rsp_load_data;
  logic              we_q;
  logic              re_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;

  mdio_pb_decode #(
    .PAGE_W       (PAGE_W),
    .PAGE_PHY     (PAGE_PHY),
    .PAGE_REG     (PAGE_REG),
    .DATA_PHY_BASE(DATA_PHY_BASE)
  ) u_dec (
    .phy     (req_phy),
    .regn    (req_reg),
    .page    (page_q),
    .kind    (kind),
    .hi_half (hi_half),
    .word_idx(word_idx)
  );

  assign req_ready = !busy;
  assign take      = req_valid && req_ready;

  // Page register: loaded by a page-select write only
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
    end else if (take && req_write && kind == ACC_PAGE) begin
      page_q <= req_wdata[PAGE_W-1:0];
    end
  end

  // Holding registers for the two upper halves
  always_comb begin
    hold_load             = '0;
    hold_load[HOLD_STAGE] = take && req_write && kind == ACC_DATA && hi_half;
    hold_load[HOLD_SNAP]  = re_q;
  end

  mdio_pb_halves #(.HALF_W(HALF_W)) u_halves (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (hold_load),
    .stage_in(req_wdata),
    .snap_in (reg_rdata[WORD_W-1:HALF_W]),
    .stage_q (stage_q),
    .snap_q  (snap_q)
  );

  // Internal bus issue stage: strobes are one cycle after acceptance
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      we_q <= take && req_write && kind == ACC_DATA && !hi_half;
      re_q <= take && !req_write && kind == ACC_DATA && !hi_half;
      if (take && kind == ACC_DATA && !hi_half) begin
        addr_q <= {word_idx, 2'b00};
        if (req_write) begin
          wdata_q <= {stage_q, req_wdata};
        end
      end
    end
  end

  assign reg_we    = we_q;
  assign reg_re    = re_q;
  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;

  // Response source selection
  always_comb begin
    rsp_load      = 1'b0;
    rsp_load_data = IDLE_READ;
    if (re_q) begin
      rsp_load      = 1'b1;
      rsp_load_data = reg_rdata[HALF_W-1:0];
    end else if (take && !req_write) begin
      unique case (kind)
        ACC_PAGE: begin
          rsp_load      = 1'b1;
          rsp_load_data = HALF_W'(page_q);
        end
        ACC_DATA: begin
          rsp_load      = hi_half;
          rsp_load_data = snap_q;
        end
        default: begin
          rsp_load      = 1'b1;
          rsp_load_data = IDLE_READ;
        end
      endcase
    end
  end

  mdio_pb_resp #(.HALF_W(HALF_W)) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .read_take(take && !req_write),
    .load     (rsp_load),
    .load_data(rsp_load_data),
    .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data),
    .busy     (busy)
  );

endmodule

// File: rtl/mdio_page_bridge_chk.sv
module mdio_page_bridge_chk #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned HALF_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [HALF_W-1:0] rsp_data,
  input logic              reg_we,
  input logic              reg_re
);

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({reg_we, reg_re}) <= 1);

  assert_we_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(req_valid && req_ready && req_write));

  assert_re_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |-> $past(req_valid && req_ready && !req_write));

  assert_rsp_follows_re_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> rsp_valid);

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || reg_re) |-> !req_ready);

endmodule

bind mdio_page_bridge mdio_page_bridge_chk #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_write(req_write),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_data (rsp_data),
  .reg_we   (reg_we),
  .reg_re   (reg_re)
);

// File: tb/sim_mdio_page_bridge.sv
`timescale 1ns/1ps
module sim_mdio_page_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [15:0] rsp_data;
  logic [17:0] reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_we;
  logic        reg_re;
  logic [31:0] reg_rdata;
  logic [15:0] salt = '0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  // Bus model: upper half = word index ^ 0x5A5A ^ salt, lower half = word index
  assign reg_rdata = {reg_addr[17:2] ^ 16'h5A5A ^ salt, reg_addr[17:2]};

  mdio_page_bridge u0 (.*);

  typedef struct packed {
    logic        w;
    logic [4:0]  p;
    logic [4:0]  r;
    logic [15:0] d;
    logic        we;
    logic        re;
    logic [17:0] a;
    logic [31:0] x;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 5'h1F, 5'h10, 16'h0155, 1'b0, 1'b0, 18'h0,     32'h0,        4'd2}, // R2 page load
    '{1'b0, 5'h1F, 5'h10, 16'h0,    1'b0, 1'b0, 18'h0,     32'h0155,     4'd2}, // R2 page readback
    '{1'b1, 5'h13, 5'h05, 16'hBEEF, 1'b0, 1'b0, 18'h0,     32'h0,        4'd4}, // R4 stage high half
    '{1'b1, 5'h13, 5'h04, 16'h1234, 1'b1, 1'b0, 18'h2AAC8, 32'hBEEF1234, 4'd5}, // R5 R3 low half write
    '{1'b0, 5'h17, 5'h1E, 16'h0,    1'b0, 1'b1, 18'h2ABFC, 32'hAAFF,     4'd6}, // R6 R3 low half read
    '{1'b0, 5'h17, 5'h1F, 16'h0,    1'b0, 1'b0, 18'h0,     32'hF0A5,     4'd7}, // R7 high half read
    '{1'b1, 5'h10, 5'h00, 16'h0001, 1'b1, 1'b0, 18'h2AA00, 32'hBEEF0001, 4'd5}, // R5 stage kept
    '{1'b1, 5'h18, 5'h05, 16'h7777, 1'b0, 1'b0, 18'h0,     32'h0,        4'd8}, // R8 ignored write
    '{1'b0, 5'h08, 5'h02, 16'h0,    1'b0, 1'b0, 18'h0,     32'hFFFF,     4'd8}, // R8 ignored read
    '{1'b1, 5'h12, 5'h00, 16'h0000, 1'b1, 1'b0, 18'h2AA80, 32'hBEEF0000, 4'd8}, // R8 stage untouched
    '{1'b1, 5'h1F, 5'h10, 16'hFE00, 1'b0, 1'b0, 18'h0,     32'h0,        4'd2}, // R2 only bits 8:0
    '{1'b0, 5'h1F, 5'h10, 16'h0,    1'b0, 1'b0, 18'h0,     32'h0000,     4'd2},
    '{1'b1, 5'h1F, 5'h11, 16'h00AA, 1'b0, 1'b0, 18'h0,     32'h0,        4'd8}, // R8 other reg on page PHY
    '{1'b0, 5'h1F, 5'h10, 16'h0,    1'b0, 1'b0, 18'h0,     32'h0000,     4'd8},
    '{1'b1, 5'h11, 5'h03, 16'hCAFE, 1'b0, 1'b0, 18'h0,     32'h0,        4'd4},
    '{1'b1, 5'h11, 5'h02, 16'h0BAD, 1'b1, 1'b0, 18'h00044, 32'hCAFE0BAD, 4'd3}, // R3 page zero
    '{1'b1, 5'h1F, 5'h10, 16'h01FF, 1'b0, 1'b0, 18'h0,     32'h0,        4'd2},
    '{1'b0, 5'h16, 5'h1C, 16'h0,    1'b0, 1'b1, 18'h3FFB8, 32'hFFEE,     4'd3}, // R3 page all ones
    '{1'b0, 5'h16, 5'h1D, 16'h0,    1'b0, 1'b0, 18'h0,     32'hA5B4,     4'd7}
  };

  task automatic chk(input logic ok, input int rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic send(input logic w, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d,
                      output logic we_s, output logic re_s, output logic [17:0] a_s,
                      output logic [31:0] wd_s, output logic [15:0] rd_s, output logic tim_ok);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_phy = p; req_reg = r; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    we_s = reg_we; re_s = reg_re; a_s = reg_addr; wd_s = reg_wdata;
    rd_s = '0; tim_ok = 1'b1;
    if (!w) begin
      if (re_s) begin
        tim_ok = !rsp_valid;
        @(negedge clk);
      end
      tim_ok = tim_ok && rsp_valid;
      rd_s = rsp_data;
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic we_s, re_s, tim_ok;
    logic [17:0] a_s;
    logic [31:0] wd_s;
    logic [15:0] rd_s;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    chk(req_ready == 1'b1, 1, 32'(req_ready), 32'h1);
    chk(rsp_valid == 1'b0, 1, 32'(rsp_valid), 32'h0);
    chk({reg_we, reg_re} == 2'b00, 1, 32'({reg_we, reg_re}), 32'h0);
    send(1'b0, 5'h1F, 5'h10, 16'h0, we_s, re_s, a_s, wd_s, rd_s, tim_ok);
    chk(rd_s == 16'h0 && tim_ok, 1, 32'(rd_s), 32'h0); // R1 page resets to zero

    for (int i = 0; i < NV; i++) begin
      send(TBL[i].w, TBL[i].p, TBL[i].r, TBL[i].d, we_s, re_s, a_s, wd_s, rd_s, tim_ok);
      chk(we_s == TBL[i].we && re_s == TBL[i].re, int'(TBL[i].req),
          32'({we_s, re_s}), 32'({TBL[i].we, TBL[i].re}));
      if (we_s || re_s)
        chk(a_s == TBL[i].a, int'(TBL[i].req), 32'(a_s), 32'(TBL[i].a));
      if (TBL[i].we)
        chk(wd_s == TBL[i].x, int'(TBL[i].req), wd_s, TBL[i].x);
      if (!TBL[i].w)
        chk(rd_s == TBL[i].x[15:0] && tim_ok, int'(TBL[i].req), 32'(rd_s), TBL[i].x);
    end

    // R7: high half comes from the snapshot, not the current bus word
    send(1'b0, 5'h10, 5'h00, 16'h0, we_s, re_s, a_s, wd_s, rd_s, tim_ok);
    chk(rd_s == 16'hFF80 && tim_ok, 7, 32'(rd_s), 32'hFF80);
    salt = 16'h1111;
    send(1'b0, 5'h10, 5'h01, 16'h0, we_s, re_s, a_s, wd_s, rd_s, tim_ok);
    chk(rd_s == 16'hA5DA && !re_s, 7, 32'(rd_s), 32'hA5DA);

    // R9: back-pressure on the response
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_phy = 5'h1F; req_reg = 5'h10;
    @(negedge clk);
    req_write = 1'b1; req_phy = 5'h10; req_reg = 5'h00; req_wdata = 16'h4321;
    for (int k = 0; k < 3; k++) begin
      chk(rsp_valid && rsp_data == 16'h01FF, 9, 32'(rsp_data), 32'h01FF);
      chk(!req_ready && !reg_we, 9, 32'({req_ready, reg_we}), 32'h0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, 9, 32'({rsp_valid, req_ready}), 32'h1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(reg_we && reg_addr == 18'h3FE00 && reg_wdata == 32'hCAFE4321, 5, reg_wdata, 32'hCAFE4321);
    chk(!(reg_we && reg_re), 10, 32'({reg_we, reg_re}), 32'h2);
    @(negedge clk);
    chk(!reg_we, 5, 32'(reg_we), 32'h0); // single-cycle strobe

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule